// File: doc/BRIEF.md
# Two-Thread Repartitioning Return Address Stack

This block predicts return targets for a core that runs two hardware threads. It holds a single pool of return-address entries whose split between the threads depends on the core's thread mode. When both threads are in the active power state (C0), each thread owns one private half of the pool. When one thread asks to leave C0, for example through a halt or a monitor-wait for a deeper state, the core falls back to single-thread operation. The thread that stays active then uses the whole pool as one larger stack. The mode is set again when the idle thread re-enters C0.

A switch between modes never touches the stored entries. Only the stack pointers are re-interpreted. This means the active thread in single-thread mode can walk into entries that its sibling pushed before going idle, and then return to one of those targets. A configuration bit closes this hole. When the bit is set, the sibling's half is invalidated on the same clock edge that enters single-thread mode. As a software-side guard, a thread can also push a run of safe return addresses before it goes idle, and those pushes are accepted like any other call.

The fetch stage drives a per-thread call strobe with the return address and a per-thread return strobe. It reads back a per-thread predicted target and a valid flag, both taken combinationally from the entry at that thread's current top of stack.

Top module: `smt_ras`

## Requirements
- R1: After reset every entry is invalid and the block is in dual mode. Thread 0's pointer sits at entry 0 and thread 1's at entry 16, so neither thread reports a valid prediction until it pushes.
- R2: In dual mode thread t owns entries 16*t to 16*t+15. A call first advances the thread's pointer by one, wrapping within those 16 entries, and then writes the address there and marks it valid. A return moves the pointer back by one with the same wrap. One thread never reads or writes the other thread's half.
- R3: In dual mode, when exactly one thread is in C0 (bit t of the active input high), the next edge enters solo mode for that thread. In solo mode its pointer advances and retreats with wrap over all 32 entries.
- R4: Entering solo mode keeps the active thread's absolute pointer and every stored entry as they are. With scrubbing off, stepping back past the start of its own half reaches the idle thread's entries, and those give valid predictions.
- R5: With the scrub enable high, the edge that enters solo mode clears the valid bits of the idle thread's half. No return issued afterwards predicts from an entry the idle thread pushed.
- R6: In solo mode, when the idle thread is back in C0, the next edge returns to dual mode. The solo thread's pointer keeps its low four bits and is moved back into its own half. The other thread's pointer and entries are unchanged.
- R7: A return whose top entry is invalid reports valid low, and the pointer still moves back.
- R8: A call and a return from the same thread in one cycle report the current top. They then overwrite that same entry with the new address and leave the pointer where it was.
- R9: Calls and returns are ignored, and valid is held low, for a thread that is out of C0. The same holds for a thread that is in C0 but not the solo owner while the core is still in solo mode.
- R10: The predicted target and valid flag of an accepting thread reflect the entry under its pointer in the same cycle, without a register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scrub_en_i | input | 1 | Invalidate the idle thread's half on entering solo mode |
| c0_act_i | input | 2 | Bit t high: thread t is in C0 |
| call_i | input | 2 | Bit t: thread t call (push) |
| ret_i | input | 2 | Bit t: thread t return (pop) |
| call_addr_i | input | 2 x ADDR_W | Return address pushed by each thread |
| pred_tgt_o | output | 2 x ADDR_W | Predicted return target per thread |
| pred_vld_o | output | 2 | Prediction valid per thread |

## Verification
On every cycle the assertions check several conditions. The mode controller must move between dual and solo exactly when the C0 inputs call for it. Dual-mode pointers must stay inside their own halves, and a returning solo pointer must snap home. A scrub must leave the idle half fully invalid, the two write ports must never collide, and an idle or ignored thread must never change its pointer or raise valid. What the assertions cannot show is the content of predictions. That covers LIFO order through the 16- and 32-entry wraps, leakage of the sibling's stale targets with scrubbing off and its absence with scrubbing on, and restoration of the sleeping thread's stack on re-entry. These come from the bench's behavioural model and its directed mode-switch scenarios.

// File: rtl/smt_ras_pkg.sv
package smt_ras_pkg;

    // Core thread mode as seen by the return stack.
    typedef enum logic [1:0] {
        MODE_DUAL  = 2'd0,   // both threads in C0, halves private
        MODE_SOLO0 = 2'd1,   // thread 0 owns the whole pool
        MODE_SOLO1 = 2'd2    // thread 1 owns the whole pool
    } smt_mode_e;

endpackage

// File: rtl/smt_ras_mode_ctl.sv
module smt_ras_mode_ctl
    import smt_ras_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scrub_en_i,
    input  logic [1:0] c0_act_i,
    output smt_mode_e  mode_o,
    output logic [1:0] solo_own_o,
    output logic [1:0] snap_o,
    output logic [1:0] scrub_clr_o
);

    smt_mode_e mode_q;
    smt_mode_e mode_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_DUAL;
        else        mode_q <= mode_d;
    end

    // Transitions.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_DUAL: begin
                if (c0_act_i == 2'b01)      mode_d = MODE_SOLO0;
                else if (c0_act_i == 2'b10) mode_d = MODE_SOLO1;
            end
            MODE_SOLO0: if (c0_act_i[1]) mode_d = MODE_DUAL;
            MODE_SOLO1: if (c0_act_i[0]) mode_d = MODE_DUAL;
            default:    mode_d = MODE_DUAL;
        endcase
    end

    // Outputs.
    always_comb begin
        solo_own_o  = 2'b00;
        snap_o      = 2'b00;
        scrub_clr_o = 2'b00;
        unique case (mode_q)
            MODE_DUAL: begin
                if (scrub_en_i && mode_d == MODE_SOLO0) scrub_clr_o = 2'b10;
                if (scrub_en_i && mode_d == MODE_SOLO1) scrub_clr_o = 2'b01;
            end
            MODE_SOLO0: begin
                solo_own_o = 2'b01;
                if (mode_d == MODE_DUAL) snap_o = 2'b01;
            end
            MODE_SOLO1: begin
                solo_own_o = 2'b10;
                if (mode_d == MODE_DUAL) snap_o = 2'b10;
            end
            default: ;
        endcase
    end

    assign mode_o = mode_q;

    p_enter_solo0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DUAL && c0_act_i == 2'b01) |=> (mode_q == MODE_SOLO0));
    p_enter_solo1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DUAL && c0_act_i == 2'b10) |=> (mode_q == MODE_SOLO1));
    p_rejoin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_DUAL && c0_act_i == 2'b11) |=> (mode_q == MODE_DUAL));
    p_dual_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DUAL && (c0_act_i == 2'b11 || c0_act_i == 2'b00)) |=> (mode_q == MODE_DUAL));

endmodule

// File: rtl/smt_ras_ptr.sv
module smt_ras_ptr #(
    parameter int TID   = 0,
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_i,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             full_i,
    input  logic             snap_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o
);

    localparam int              LOW_W   = PTR_W - 1;
    localparam logic            TID_BIT = (TID != 0);
    localparam logic [LOW_W-1:0] ONE_L  = 1;
    localparam logic [PTR_W-1:0] ONE_P  = 1;

    logic [PTR_W-1:0] ptr_q, ptr_d, ptr_inc, ptr_dec;

    always_comb begin
        if (full_i) begin
            ptr_inc = ptr_q + ONE_P;
            ptr_dec = ptr_q - ONE_P;
        end else begin
            ptr_inc = {TID_BIT, ptr_q[LOW_W-1:0] + ONE_L};
            ptr_dec = {TID_BIT, ptr_q[LOW_W-1:0] - ONE_L};
        end
    end

    always_comb begin
        ptr_d    = ptr_q;
        wr_en_o  = 1'b0;
        wr_idx_o = ptr_inc;
        if (acc_i) begin
            if (push_i && pop_i) begin
                wr_en_o  = 1'b1;
                wr_idx_o = ptr_q;
            end else if (push_i) begin
                wr_en_o  = 1'b1;
                ptr_d    = ptr_inc;
            end else if (pop_i) begin
                ptr_d    = ptr_dec;
            end
        end
        if (snap_i) ptr_d[PTR_W-1] = TID_BIT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= {TID_BIT, {LOW_W{1'b0}}};
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

    p_swap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && push_i && pop_i && !snap_i) |=> $stable(ptr_q));
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_i && !snap_i) |=> $stable(ptr_q));
    p_snap_home_r6: assert property (@(posedge clk) disable iff (!rst_n)
        snap_i |=> (ptr_q[PTR_W-1] == TID_BIT));

endmodule

// File: rtl/smt_ras_store.sv
module smt_ras_store #(
    parameter int ADDR_W = 32,
    parameter int HALF   = 16,
    parameter int PTR_W  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             we_i,
    input  logic [1:0][PTR_W-1:0]  widx_i,
    input  logic [1:0][ADDR_W-1:0] wdata_i,
    input  logic [1:0]             clr_half_i,
    input  logic [1:0][PTR_W-1:0]  ridx_i,
    output logic [1:0][ADDR_W-1:0] rdata_o,
    output logic [1:0]             rvld_o
);

    localparam int DEPTH = 2 * HALF;

    logic [ADDR_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  vld_q;

    always_ff @(posedge clk) begin
        for (int p = 0; p < 2; p++) begin
            if (we_i[p]) mem[widx_i[p]] <= wdata_i[p];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (clr_half_i[i / HALF]) vld_q[i] <= 1'b0;
            end
            for (int p = 0; p < 2; p++) begin
                if (we_i[p]) vld_q[widx_i[p]] <= 1'b1;
            end
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        assign rdata_o[p] = mem[ridx_i[p]];
        assign rvld_o[p]  = vld_q[ridx_i[p]];
    end

    p_wr_disjoint_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i == 2'b11 && widx_i[0] == widx_i[1]));
    p_scrub_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_half_i[0] |=> (vld_q[HALF-1:0] == '0));
    p_scrub_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_half_i[1] |=> (vld_q[DEPTH-1:HALF] == '0));

endmodule

// File: rtl/smt_ras.sv
module smt_ras
    import smt_ras_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int HALF   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scrub_en_i,
    input  logic [1:0]             c0_act_i,
    input  logic [1:0]             call_i,
    input  logic [1:0]             ret_i,
    input  logic [1:0][ADDR_W-1:0] call_addr_i,
    output logic [1:0][ADDR_W-1:0] pred_tgt_o,
    output logic [1:0]             pred_vld_o
);

    localparam int DEPTH = 2 * HALF;
    localparam int PTR_W = $clog2(DEPTH);

    smt_mode_e              mode;
    logic [1:0]             solo_own, snap, scrub_clr, acc, we, rvld;
    logic [1:0][PTR_W-1:0]  ptr, widx;

    smt_ras_mode_ctl u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .scrub_en_i  (scrub_en_i),
        .c0_act_i    (c0_act_i),
        .mode_o      (mode),
        .solo_own_o  (solo_own),
        .snap_o      (snap),
        .scrub_clr_o (scrub_clr)
    );

    for (genvar t = 0; t < 2; t++) begin : g_thr
        assign acc[t] = c0_act_i[t] && (mode == MODE_DUAL || solo_own[t]);

        smt_ras_ptr #(.TID(t), .PTR_W(PTR_W)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc_i    (acc[t]),
            .push_i   (call_i[t]),
            .pop_i    (ret_i[t]),
            .full_i   (solo_own[t]),
            .snap_i   (snap[t]),
            .ptr_o    (ptr[t]),
            .wr_en_o  (we[t]),
            .wr_idx_o (widx[t])
        );

        assign pred_vld_o[t] = acc[t] && rvld[t];
    end

    smt_ras_store #(.ADDR_W(ADDR_W), .HALF(HALF), .PTR_W(PTR_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (we),
        .widx_i     (widx),
        .wdata_i    (call_addr_i),
        .clr_half_i (scrub_clr),
        .ridx_i     (ptr),
        .rdata_o    (pred_tgt_o),
        .rvld_o     (rvld)
    );

    p_dual_home_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DUAL) |-> (ptr[0][PTR_W-1] == 1'b0 && ptr[1][PTR_W-1] == 1'b1));
    p_idle_silent0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !c0_act_i[0] |-> !pred_vld_o[0]);
    p_idle_silent1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !c0_act_i[1] |-> !pred_vld_o[1]);
    p_solo_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_DUAL) |-> !(pred_vld_o == 2'b11));

endmodule

// File: tb/smt_ras_tb.sv
module smt_ras_tb;

    localparam int AW = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             scrub_en = 1'b0;
    logic [1:0]       c0 = 2'b11, call = 2'b00, ret = 2'b00;
    logic [1:0][AW-1:0] addr = '0;
    logic [1:0][AW-1:0] tgt;
    logic [1:0]       vld;

    always #2 clk = ~clk;   // 250 MHz

    smt_ras u_dut (
        .clk(clk), .rst_n(rst_n), .scrub_en_i(scrub_en), .c0_act_i(c0),
        .call_i(call), .ret_i(ret), .call_addr_i(addr),
        .pred_tgt_o(tgt), .pred_vld_o(vld)
    );

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    string cur_req = "R1";

    // behavioural reference: 0 = dual, 1 = solo thread 0, 2 = solo thread 1
    int       m_mode;
    int       m_ptr [2];
    logic [AW-1:0] m_mem [32];
    bit       m_vld [32];

    task automatic m_reset();
        m_mode = 0; m_ptr[0] = 0; m_ptr[1] = 16;
        for (int i = 0; i < 32; i++) m_vld[i] = 0;
    endtask

    function automatic bit m_acc(int t);
        return c0[t] && (m_mode == 0 || m_mode == t + 1);
    endfunction

    function automatic int m_step(int t, int p, int d);
        if (m_mode == t + 1) return (p + d + 32) % 32;
        return t * 16 + ((p % 16) + d + 16) % 16;
    endfunction

    task automatic m_clock();
        int nm;
        for (int t = 0; t < 2; t++) begin
            if (m_acc(t)) begin
                if (call[t] && ret[t]) begin
                    m_mem[m_ptr[t]] = addr[t]; m_vld[m_ptr[t]] = 1;
                end else if (call[t]) begin
                    m_ptr[t] = m_step(t, m_ptr[t], 1);
                    m_mem[m_ptr[t]] = addr[t]; m_vld[m_ptr[t]] = 1;
                end else if (ret[t]) begin
                    m_ptr[t] = m_step(t, m_ptr[t], -1);
                end
            end
        end
        nm = m_mode;
        if (m_mode == 0) begin
            if (c0 == 2'b01) nm = 1;
            if (c0 == 2'b10) nm = 2;
            if (nm != 0 && scrub_en)
                for (int i = 0; i < 16; i++) m_vld[(2 - nm) * 16 + i] = 0;
        end else if (c0[2 - m_mode]) begin
            nm = 0;
            m_ptr[m_mode - 1] = (m_mode - 1) * 16 + (m_ptr[m_mode - 1] % 16);
        end
        m_mode = nm;
    endtask

    task automatic compare();
        for (int t = 0; t < 2; t++) begin
            bit ev;
            ev = m_acc(t) && m_vld[m_ptr[t]];
            vectors++;
            if (vld[t] !== ev || (ev && tgt[t] !== m_mem[m_ptr[t]])) begin
                fails++;
                $display("FAIL %s thread%0d: got vld=%0b tgt=%h, expected vld=%0b tgt=%h",
                         cur_req, t, vld[t], tgt[t], ev, m_mem[m_ptr[t]]);
            end
        end
    endtask

    task automatic apply(input logic [1:0] c, input logic [1:0] cl, input logic [1:0] rt,
                         input logic [AW-1:0] a0, input logic [AW-1:0] a1);
        c0 = c; call = cl; ret = rt; addr[0] = a0; addr[1] = a1;
        #1;
        compare();
    endtask

    task automatic tick();
        @(posedge clk);
        m_clock();
        @(negedge clk);
    endtask

    task automatic step(input logic [1:0] c, input logic [1:0] cl, input logic [1:0] rt,
                        input logic [AW-1:0] a0, input logic [AW-1:0] a1);
        apply(c, cl, rt, a0, a1);
        tick();
    endtask

    // hand-computed check on one thread's current prediction
    task automatic chk(input int t, input bit ev, input logic [AW-1:0] et, input string req);
        vectors++;
        if (vld[t] !== ev || (ev && tgt[t] !== et)) begin
            fails++;
            $display("FAIL %s thread%0d: got vld=%0b tgt=%h, expected vld=%0b tgt=%h",
                     req, t, vld[t], tgt[t], ev, et);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; c0 = 2'b11; call = 0; ret = 0; addr = '0;
        @(negedge clk); @(negedge clk);
        m_reset();
        rst_n = 1'b1;
    endtask

    // leakage scenario: thread 0 walks below its half after thread 1 sleeps
    task automatic leak_scenario(input bit scrub);
        do_reset();
        scrub_en = scrub;
        cur_req = scrub ? "R5" : "R4";
        step(2'b11, 2'b01, 2'b00, 32'hAAAA_0001, 0);
        for (int i = 1; i <= 15; i++) step(2'b11, 2'b10, 2'b00, 0, 32'hB000_0000 + i);
        step(2'b01, 2'b00, 2'b00, 0, 0);                       // enter solo 0
        apply(2'b01, 2'b00, 2'b01, 0, 0);
        chk(0, 1, 32'hAAAA_0001, "R10");
        tick();
        apply(2'b01, 2'b00, 2'b01, 0, 0);
        chk(0, 0, 0, "R7");
        tick();
        apply(2'b01, 2'b00, 2'b00, 0, 0);                      // top is entry 31
        if (scrub) chk(0, 0, 0, "R5");
        else       chk(0, 1, 32'hB000_000F, "R4");
        chk(1, 0, 0, "R9");
        tick();
        apply(2'b11, 2'b10, 2'b00, 0, 32'hDEAD_0000);           // not owner yet
        chk(1, 0, 0, "R9");
        tick();
        cur_req = "R6";
        apply(2'b11, 2'b00, 2'b00, 0, 0);
        if (scrub) chk(1, 0, 0, "R6");
        else       chk(1, 1, 32'hB000_000F, "R6");
        chk(0, 0, 0, "R6");                                    // snapped to 15
        tick();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: got cycle=%0d, expected below 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        cur_req = "R1";
        apply(2'b11, 2'b00, 2'b11, 0, 0);
        chk(0, 0, 0, "R1");
        chk(1, 0, 0, "R1");
        tick();
        do_reset();

        cur_req = "R2";
        step(2'b11, 2'b11, 2'b00, 32'h100, 32'h200);
        apply(2'b11, 2'b00, 2'b00, 0, 0);
        chk(0, 1, 32'h100, "R2");
        chk(1, 1, 32'h200, "R2");
        tick();
        for (int i = 0; i < 17; i++) step(2'b11, 2'b01, 2'b00, 32'h1000 + i, 0);
        for (int i = 0; i < 17; i++) step(2'b11, 2'b00, 2'b01, 0, 0);
        apply(2'b11, 2'b00, 2'b00, 0, 0);
        chk(1, 1, 32'h200, "R2");
        tick();

        cur_req = "R8";
        apply(2'b11, 2'b10, 2'b10, 0, 32'h300);
        chk(1, 1, 32'h200, "R8");
        tick();
        apply(2'b11, 2'b00, 2'b00, 0, 0);
        chk(1, 1, 32'h300, "R8");
        tick();
        step(2'b11, 2'b00, 2'b10, 0, 0);

        cur_req = "R3";
        step(2'b01, 2'b00, 2'b00, 0, 0);
        for (int i = 0; i < 34; i++) step(2'b01, 2'b01, 2'b00, 32'h5000 + i, 0);
        for (int i = 0; i < 34; i++) step(2'b01, 2'b00, 2'b01, 0, 0);
        step(2'b11, 2'b00, 2'b00, 0, 0);

        leak_scenario(1'b0);
        leak_scenario(1'b1);

        cur_req = "R10";
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] c, cl, rt;
            c  = ($urandom % 16 == 0) ? 2'($urandom) : c0;
            cl = 2'($urandom) & 2'($urandom);
            rt = 2'($urandom) & 2'($urandom);
            if ($urandom % 64 == 0) scrub_en = ~scrub_en;
            step(c, cl, rt, $urandom, $urandom);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule